// File: doc/BRIEF.md
# Branch-on-Bit Instruction Sequencer

This block carries out the two conditional instructions that test one bit of a byte on page zero and jump relative to the program counter when that bit has the wanted value. One form jumps when the bit is clear and the other when the bit is set. The sequencer starts once the opcode has been fetched. It reads the page-zero address operand and then the signed 8-bit displacement. It then reads the addressed data byte, tests the chosen bit and produces the next program counter.

A core's control unit pulses `start` with the opcode and the address of the first operand byte. The sequencer then issues its own memory reads and returns the new program counter together with a `taken` flag in a single-cycle `done` pulse. The cycle count does not depend on page crossings. A taken branch costs exactly one cycle more than a fall-through, so the instruction stays one cycle longer than a plain relative branch in both outcomes.

Top module: `bbx_branch_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `taken` and `mem_rd` are 0 and `pc_out` is 0x0000.
- R2: After `start` is accepted at clock edge 0, `mem_rd` is high for exactly three cycles. In those cycles `mem_addr` is `pc_in`, then `pc_in+1`, then `{0x00, address operand}`. The read data is taken in the same cycle the address is shown.
- R3: Opcode bits [6:4] give the bit index and opcode bit 7 gives the polarity. With bit 7 = 0 the branch is taken when the data bit is 0. With bit 7 = 1 it is taken when the data bit is 1. Opcode bits [3:0] have no effect.
- R4: When the branch is taken, `pc_out` = `pc_in` + 2 + sign-extended displacement, modulo 2^16. Displacement 0x00 gives `pc_in`+2, values 0x01–0x7F jump forward and 0x80–0xFF jump backward.
- R5: When the branch is not taken, `pc_out` = `pc_in` + 2 and `taken` = 0.
- R6: `done` rises at clock edge 3 when the branch is not taken and at edge 4 when it is taken. No extra cycle is added when the target lies on another page.
- R7: `done` is high for one cycle only. `taken` is valid in that cycle and 0 at all other times. `busy` is high from edge 0 until the edge where `done` rises.
- R8: `start` is ignored while `busy` is high. Such a pulse changes neither the result nor the timing of the running instruction.
- R9: `pc_out` holds its value except at the edge where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (only accepted when idle) |
| opcode | input | 8 | Opcode: [7] polarity, [6:4] bit index |
| pc_in | input | 16 | Address of the first operand byte |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken, valid with `done` |
| pc_out | output | 16 | Next program counter |

## Verification
The assertions assume that memory answers without delay: `mem_rdata` must reflect `mem_addr` within the same cycle. They also assume `start` is a pulse of plain 0/1 values, so that a rise of `busy` can always be traced to an accepted `start`. The bench models memory as combinational logic that returns the two operand bytes at `pc_in` and `pc_in+1` and a page-zero array elsewhere. It keeps the operand bytes off page zero so the three reads never alias. Random opcodes, data bytes and displacements are mixed with directed wrap, page-crossing and edge-displacement cases, plus `start` pulses injected during busy.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ZP   = 3'd1,
    S_OFS  = 3'd2,
    S_BIT  = 3'd3,
    S_TAKE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/bbx_bit_test.sv
module bbx_bit_test #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic [DW-1:0]    data,
  input  logic [IDX_W-1:0] idx,
  input  logic             want_set,
  output logic             hit
);
  logic [DW-1:0] match;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_lane
      assign match[i] = (idx == IDX_W'(i)) && (data[i] == want_set);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    assert ($onehot0(match)) else $error("assert_single_lane_R3");
  end
endmodule

// File: rtl/bbx_target.sv
module bbx_target #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] target
);
  logic [AW-1:0] disp_ext;

  assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
  assign target   = base + disp_ext;
endmodule

// File: rtl/bbx_branch_seq.sv
module bbx_branch_seq
  import bbx_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int IDX_LSB = 4,
  parameter int POL_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          busy,
  output logic          done,
  output logic          taken,
  output logic [AW-1:0] pc_out
);
  localparam int IDX_W = $clog2(DW);
  localparam logic [AW-1:0] STEP1 = AW'(1);
  localparam logic [AW-1:0] STEP2 = AW'(2);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx_q;
  logic              pol_q;
  logic [AW-1:0]     pc_q;
  logic [DW-1:0]     zp_q;
  logic [DW-1:0]     disp_q;
  logic [AW-1:0]     tgt_q;
  logic [AW-1:0]     fall_pc;
  logic [AW-1:0]     jump_pc;
  logic              bit_hit;

  assign fall_pc = pc_q + STEP2;

  bbx_bit_test #(.DW(DW), .IDX_W(IDX_W)) u_test (
    .data     (mem_rdata),
    .idx      (idx_q),
    .want_set (pol_q),
    .hit      (bit_hit)
  );

  bbx_target #(.AW(AW), .DW(DW)) u_tgt (
    .base   (fall_pc),
    .disp   (disp_q),
    .target (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      idx_q    <= '0;
      pol_q    <= 1'b0;
      pc_q     <= '0;
      zp_q     <= '0;
      disp_q   <= '0;
      tgt_q    <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      taken    <= 1'b0;
      pc_out   <= '0;
    end else begin
      done  <= 1'b0;
      taken <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            idx_q    <= opcode[IDX_LSB +: IDX_W];
            pol_q    <= opcode[POL_BIT];
            pc_q     <= pc_in;
            mem_addr <= pc_in;
            mem_rd   <= 1'b1;
            busy     <= 1'b1;
            state    <= S_ZP;
          end
        end
        S_ZP: begin
          zp_q     <= mem_rdata;
          mem_addr <= pc_q + STEP1;
          state    <= S_OFS;
        end
        S_OFS: begin
          disp_q   <= mem_rdata;
          mem_addr <= {{(AW-DW){1'b0}}, zp_q};
          state    <= S_BIT;
        end
        S_BIT: begin
          mem_rd <= 1'b0;
          if (bit_hit) begin
            tgt_q <= jump_pc;
            state <= S_TAKE;
          end else begin
            pc_out <= fall_pc;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= S_IDLE;
          end
        end
        S_TAKE: begin
          pc_out <= tgt_q;
          done   <= 1'b1;
          taken  <= 1'b1;
          busy   <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker-side cycle counter for the latency window
  logic [2:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)                 lat_cnt <= '0;
    else if (!busy && start) lat_cnt <= '0;
    else if (busy)           lat_cnt <= lat_cnt + 3'd1;
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == (taken ? 3'd4 : 3'd3)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_taken_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    taken |-> done);

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_read_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pc_out));
endmodule

// File: tb/bbx_branch_seq_tb.sv
`timescale 1ns/1ps
module bbx_branch_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [7:0]  opcode;
  logic [15:0] pc_in;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        busy, done, taken;
  logic [15:0] pc_out;

  int checks = 0;
  int errors = 0;

  logic [7:0]  zmem [256];
  logic [15:0] m_pc;
  logic [7:0]  m_op0, m_op1;

  always #2.5 clk = ~clk;

  bbx_branch_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .busy(busy), .done(done), .taken(taken), .pc_out(pc_out)
  );

  always_comb begin
    if (mem_addr == m_pc)               mem_rdata = m_op0;
    else if (mem_addr == m_pc + 16'd1)  mem_rdata = m_op1;
    else if (mem_addr[15:8] == 8'h00)   mem_rdata = zmem[mem_addr[7:0]];
    else                                mem_rdata = 8'hA5;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [7:0] op, input logic [7:0] d);
    return d[op[6:4]] == op[7];
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] pc, input logic [7:0] disp,
                                         input bit tk);
    logic [15:0] nx;
    nx = pc + 16'd2;
    return tk ? nx + {{8{disp[7]}}, disp} : nx;
  endfunction

  task automatic run_case(input logic [7:0] op, input logic [15:0] pc,
                          input logic [7:0] zp, input logic [7:0] disp,
                          input logic [7:0] dbyte, input bit poke);
    bit          tk;
    logic [15:0] epc;
    logic [15:0] eaddr [3];
    int          seen;
    logic [15:0] held;
    tk  = exp_taken(op, dbyte);
    epc = exp_pc(pc, disp, tk);
    eaddr[0] = pc; eaddr[1] = pc + 16'd1; eaddr[2] = {8'h00, zp};
    zmem[zp] = dbyte; m_pc = pc; m_op0 = zp; m_op1 = disp;
    @(negedge clk);
    opcode = op; pc_in = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int n = 1; n <= 8; n++) begin
      if (n <= 3) begin
        check(mem_rd === 1'b1, "R2 read strobe", int'(mem_rd), 1);
        check(mem_addr === eaddr[n-1], "R2 read address", int'(mem_addr), int'(eaddr[n-1]));
      end else if (!done) begin
        check(mem_rd === 1'b0, "R2 strobe off", int'(mem_rd), 0);
      end
      if (poke && n == 2) begin
        start = 1'b1; pc_in = ~pc; opcode = ~op;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        seen = n;
        break;
      end
      check(busy === 1'b1, "R7 busy while running", int'(busy), 1);
      check(taken === 1'b0, "R7 taken low outside done", int'(taken), 0);
      @(negedge clk);
    end
    start = 1'b0;
    check(seen == (tk ? 5 : 4), "R6 done latency", seen - 1, tk ? 4 : 3);
    check(taken === tk, tk ? "R3 taken" : "R5 not taken", int'(taken), int'(tk));
    check(pc_out === epc, tk ? "R4 target" : "R5 fall-through", int'(pc_out), int'(epc));
    check(busy === 1'b0, "R7 busy low at done", int'(busy), 0);
    if (poke) check(pc_out === epc, "R8 start ignored while busy", int'(pc_out), int'(epc));
    held = pc_out;
    @(negedge clk);
    check(done === 1'b0, "R7 done single pulse", int'(done), 0);
    check(pc_out === held, "R9 pc_out holds", int'(pc_out), int'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  op, zp, disp, d;
    logic [15:0] pc;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) zmem[i] = 8'h00;
    m_pc = 16'h8000; m_op0 = 8'h00; m_op1 = 8'h00;
    rst = 1'b1; start = 1'b0; opcode = 8'h00; pc_in = 16'h0000;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && taken === 1'b0 && mem_rd === 1'b0,
          "R1 reset outputs", {busy, done, taken, mem_rd}, 0);
    check(pc_out === 16'h0000, "R1 reset pc_out", int'(pc_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pc_out === 16'h0000 && busy === 1'b0, "R1 after reset", int'(pc_out), 0);

    // R3 polarity and index, low nibble ignored
    run_case(8'h3F, 16'h4000, 8'h10, 8'h10, 8'hF7, 1'b0); // bit3 clear, clear-form -> taken
    run_case(8'h30, 16'h4000, 8'h10, 8'h10, 8'h08, 1'b0); // bit3 set, clear-form -> not taken
    run_case(8'hF5, 16'h4100, 8'h20, 8'h04, 8'h80, 1'b0); // bit7 set, set-form -> taken
    run_case(8'h8A, 16'h4100, 8'h21, 8'h04, 8'hFE, 1'b0); // bit0 clear, set-form -> not taken
    // R4 displacement edges
    run_case(8'h8F, 16'h2000, 8'h01, 8'h00, 8'h01, 1'b0);
    run_case(8'h8F, 16'h2000, 8'h01, 8'h7F, 8'h01, 1'b0);
    run_case(8'h8F, 16'h2000, 8'h01, 8'h80, 8'h01, 1'b0);
    run_case(8'h8F, 16'h2000, 8'h01, 8'hFF, 8'h01, 1'b0);
    // R4 wrap modulo 2^16, R6 page crossing costs nothing
    run_case(8'h8F, 16'hFFFC, 8'h02, 8'h10, 8'h01, 1'b0);
    run_case(8'h0F, 16'h0100, 8'h03, 8'h80, 8'h00, 1'b0);
    run_case(8'h8F, 16'h12F0, 8'h04, 8'h20, 8'h01, 1'b0);
    // R8 start pulse during busy
    run_case(8'hBF, 16'h5555, 8'h05, 8'hF0, 8'h08, 1'b1);
    run_case(8'hBF, 16'h5555, 8'h05, 8'hF0, 8'h00, 1'b1);

    for (int k = 0; k < 200; k++) begin
      op   = 8'($urandom);
      zp   = 8'($urandom);
      disp = 8'($urandom);
      d    = 8'($urandom);
      pc   = {8'($urandom_range(1, 255)), 8'($urandom)};
      if (pc == 16'hFFFF) pc = 16'hFFFE;
      run_case(op, pc, zp, disp, d, (k % 7) == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule